// File: doc/BRIEF.md
# Two-Stage Battery Charge Sequencer

This block switches an external charge source for a battery pack in two stages. When the cell sits below its low-voltage threshold while a charger is connected, an active-low recovery output turns on a current-limited trickle path. That path runs regardless of temperature, the auto-start setting and the sequencer state. Fast charge is a separate gate. It is requested either by a start command carrying code 0xB5 or by a charger being plugged in while auto-start is enabled. The request then waits until every qualifying condition holds, and fast charge switches on by itself once they all do.

The sequencer has four states:
- `ST_IDLE`: no fast charge.
- `ST_PEND`: a request is waiting.
- `ST_FAST`: the fast gate is on.
- `ST_DONE`: fast charge has terminated.

The transitions are:
- A request moves `ST_IDLE` to `ST_PEND`.
- Full qualification moves `ST_PEND` to `ST_FAST`.
- Losing any qualification moves `ST_FAST` back to `ST_PEND` (suspend).
- The termination flag of the latched chemistry moves `ST_FAST` to `ST_DONE`.
- A status clear moves `ST_DONE` to `ST_IDLE`.
- An abort moves any state to `ST_IDLE`.

Termination detection is outside this block. It arrives as one done flag per chemistry: `done_li` for lithium (taper) and `done_nimh` for NiMH (negative delta).

Top module: `charge_sequencer`

## Requirements
- R1: After reset `uv_n` is 1, `fast_on` is 0 and `chg_stat` is 2'b00.
- R2: One clock after an edge where `batt_low` and `chg_present` are both 1, `uv_n` is 0. Otherwise it is 1 one clock later. It does not depend on `temp_code`, `auto_init` or the sequencer state.
- R3: `chg_stat` is 2'b10 in `ST_DONE`. Elsewhere it is 2'b01 when fast charge or trickle (`uv_n`=0) is active, and 2'b00 otherwise. The value 2'b11 never appears.
- R4: In `ST_IDLE`, `cmd_valid` with `cmd_code` = 8'hB5 moves the sequencer to `ST_PEND`. Every other code is ignored.
- R5: In `ST_IDLE`, a 0-to-1 change of `chg_present` with `auto_init`=1 is a request. With `auto_init`=0 it is not.
- R6: `temp_code` is signed with 0.125 °C per LSB. Fast charge is held off unless 0 <= `temp_code` <= 320 (0 °C to 40 °C, both bounds inclusive).
- R7: Fast charge is held off while `chg_present`=0, while `conv_valid`=0, or while `batt_low`=1.
- R8: `ST_PEND` becomes `ST_FAST` at the first clock where all holds are clear, so `fast_on` rises two clocks after a command. A lost qualification returns `ST_FAST` to `ST_PEND` one clock later, and the sequencer resumes when the holds clear.
- R9: `chem_sel` is latched on entry to `ST_FAST`. With 0 (lithium) only `done_li` terminates and `done_nimh` is ignored. With 1 (NiMH) the reverse holds.
- R10: `ST_DONE` keeps `fast_on`=0 and ignores requests until `stat_clr`, which returns the sequencer to `ST_IDLE`.
- R11: `abort` returns any state to `ST_IDLE` at the next clock, with `fast_on`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batt_low | input | 1 | Battery below low-voltage threshold |
| chg_present | input | 1 | Charge source connected |
| temp_code | input | TEMP_W | Signed temperature, 0.125 °C per LSB |
| conv_valid | input | 1 | Measurement data valid |
| chem_sel | input | 1 | Chemistry: 0 lithium, 1 NiMH |
| auto_init | input | 1 | Start fast charge when a charger is attached |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | CMD_W | Command code (0xB5 starts charge) |
| done_li | input | 1 | Lithium termination flag |
| done_nimh | input | 1 | NiMH termination flag |
| stat_clr | input | 1 | Clears completed status |
| abort | input | 1 | Cancels any charge, back to idle |
| uv_n | output | 1 | Active-low trickle/undervoltage gate |
| fast_on | output | 1 | Fast-charge gate |
| chg_stat | output | 2 | Charge status |

## Verification
Each result has a fixed latency:
- `uv_n` and a state change follow their cause by one clock.
- `fast_on` rises two clocks after a start command or a charger attach: one clock to enter `ST_PEND` and one to qualify.
- A suspend or a resume takes one clock.

The bench drives inputs on the falling edge and advances one falling edge per rising edge. Each check is placed exactly that number of edges after its stimulus, and every held condition is kept stable across the window. Temperature codes and command codes are swept over their full range near the window bounds, and the qualifying flags are swept over all sixteen combinations.

// File: rtl/chg_pkg.sv
package chg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_FAST = 2'd2,
        ST_DONE = 2'd3
    } chg_state_t;

    localparam logic [1:0] STAT_NONE     = 2'b00;
    localparam logic [1:0] STAT_CHARGING = 2'b01;
    localparam logic [1:0] STAT_COMPLETE = 2'b10;
endpackage

// File: rtl/chg_qualify.sv
module chg_qualify #(
    parameter int TEMP_W = 12,
    parameter int T_LO   = 0,
    parameter int T_HI   = 320
) (
    input  logic signed [TEMP_W-1:0] temp_code,
    input  logic                     chg_present,
    input  logic                     conv_valid,
    input  logic                     batt_low,
    output logic                     qual_ok
);
    localparam logic signed [TEMP_W-1:0] LO_C = TEMP_W'(T_LO);
    localparam logic signed [TEMP_W-1:0] HI_C = TEMP_W'(T_HI);

    logic temp_ok;

    always_comb begin
        temp_ok = (temp_code >= LO_C) && (temp_code <= HI_C);
        qual_ok = temp_ok && chg_present && conv_valid && !batt_low;
    end
endmodule

// File: rtl/chg_request.sv
module chg_request #(
    parameter int              CMD_W     = 8,
    parameter logic [CMD_W-1:0] CMD_START = 8'hB5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             chg_present,
    input  logic             auto_init,
    output logic             req
);
    logic chg_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_prev <= 1'b0;
        else        chg_prev <= chg_present;
    end

    always_comb begin
        req = (cmd_valid && (cmd_code == CMD_START))
            || (auto_init && chg_present && !chg_prev);
    end

    // R4/R5: with no strobe and no auto-start there is never a request
    p_no_spurious_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !auto_init) |-> !req);
endmodule

// File: rtl/chg_trickle.sv
module chg_trickle (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_low,
    input  logic chg_present,
    output logic uv_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uv_n <= 1'b1;
        else        uv_n <= !(batt_low && chg_present);
    end

    p_uv_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_low && chg_present) |=> !uv_n);
    p_uv_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(batt_low && chg_present) |=> uv_n);
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
    import chg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       qual_ok,
    input  logic       chem_sel,
    input  logic       done_li,
    input  logic       done_nimh,
    input  logic       stat_clr,
    input  logic       abort,
    input  logic       trickle,
    output logic       fast_on,
    output logic [1:0] chg_stat
);
    chg_state_t st, nxt;
    logic       chem_q;
    logic       term;

    always_comb begin
        term = chem_q ? done_nimh : done_li;
        nxt  = st;
        if (abort) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (req) nxt = ST_PEND;
                ST_PEND: if (qual_ok) nxt = ST_FAST;
                ST_FAST: begin
                    if (term)          nxt = ST_DONE;
                    else if (!qual_ok) nxt = ST_PEND;
                end
                ST_DONE: if (stat_clr) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            chem_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_PEND && nxt == ST_FAST) chem_q <= chem_sel;
        end
    end

    always_comb begin
        fast_on = (st == ST_FAST);
        if (st == ST_DONE)                   chg_stat = STAT_COMPLETE;
        else if (st == ST_FAST || trickle)   chg_stat = STAT_CHARGING;
        else                                 chg_stat = STAT_NONE;
    end

    p_fast_needs_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAST) |-> $past(qual_ok));
    p_idle_req_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req && !abort) |=> (st == ST_PEND));
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !abort && !stat_clr) |=> (st == ST_DONE));
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (st == ST_IDLE && !fast_on));
    p_no_stat3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stat != 2'b11);
endmodule

// File: rtl/charge_sequencer.sv
module charge_sequencer #(
    parameter int              TEMP_W    = 12,
    parameter int              T_LO      = 0,
    parameter int              T_HI      = 320,
    parameter int              CMD_W     = 8,
    parameter logic [CMD_W-1:0] CMD_START = 8'hB5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     batt_low,
    input  logic                     chg_present,
    input  logic signed [TEMP_W-1:0] temp_code,
    input  logic                     conv_valid,
    input  logic                     chem_sel,
    input  logic                     auto_init,
    input  logic                     cmd_valid,
    input  logic [CMD_W-1:0]         cmd_code,
    input  logic                     done_li,
    input  logic                     done_nimh,
    input  logic                     stat_clr,
    input  logic                     abort,
    output logic                     uv_n,
    output logic                     fast_on,
    output logic [1:0]               chg_stat
);
    logic qual_ok;
    logic req;

    chg_qualify #(.TEMP_W(TEMP_W), .T_LO(T_LO), .T_HI(T_HI)) u_qual (
        .temp_code(temp_code), .chg_present(chg_present),
        .conv_valid(conv_valid), .batt_low(batt_low), .qual_ok(qual_ok)
    );

    chg_request #(.CMD_W(CMD_W), .CMD_START(CMD_START)) u_req (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .chg_present(chg_present), .auto_init(auto_init), .req(req)
    );

    chg_trickle u_trk (
        .clk(clk), .rst_n(rst_n), .batt_low(batt_low),
        .chg_present(chg_present), .uv_n(uv_n)
    );

    chg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .qual_ok(qual_ok),
        .chem_sel(chem_sel), .done_li(done_li), .done_nimh(done_nimh),
        .stat_clr(stat_clr), .abort(abort), .trickle(!uv_n),
        .fast_on(fast_on), .chg_stat(chg_stat)
    );
endmodule

// File: tb/test_charge_sequencer.sv
module test_charge_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic batt_low = 1'b0, chg_present = 1'b0, conv_valid = 1'b0;
    logic signed [11:0] temp_code = '0;
    logic chem_sel = 1'b0, auto_init = 1'b0, cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic done_li = 1'b0, done_nimh = 1'b0, stat_clr = 1'b0, abort = 1'b0;
    logic uv_n, fast_on;
    logic [1:0] chg_stat;
    int checks = 0, fails = 0;
    bit fin = 1'b0;

    always #10 clk = ~clk;

    charge_sequencer i_charge_sequencer (
        .clk(clk), .rst_n(rst_n), .batt_low(batt_low), .chg_present(chg_present),
        .temp_code(temp_code), .conv_valid(conv_valid), .chem_sel(chem_sel),
        .auto_init(auto_init), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .done_li(done_li), .done_nimh(done_nimh), .stat_clr(stat_clr),
        .abort(abort), .uv_n(uv_n), .fast_on(fast_on), .chg_stat(chg_stat)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_abort();
        abort = 1'b1; step(); abort = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c; step(); cmd_valid = 1'b0; cmd_code = '0;
    endtask

    task automatic qualify_all();
        batt_low = 1'b0; chg_present = 1'b1; conv_valid = 1'b1; temp_code = 12'sd100;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 uv_n", uv_n, 1);
        chk("R1 fast_on", fast_on, 0);
        chk("R1 chg_stat", chg_stat, 0);
        rst_n = 1'b1;
        step();

        // R2/R3 trickle gate sweep, independent of temperature and auto_init
        for (int k = 0; k < 16; k++) begin
            batt_low = k[0]; chg_present = k[1]; auto_init = 1'b0;
            temp_code = k[2] ? -12'sd50 : 12'sd500; conv_valid = k[3];
            step();
            chk("R2 uv_n", uv_n, (k[0] && k[1]) ? 0 : 1);
            chk("R3 trickle status", chg_stat, (k[0] && k[1]) ? 1 : 0);
        end
        batt_low = 1'b0; chg_present = 1'b0; step();

        // R4 command code sweep
        qualify_all();
        for (int c = 0; c < 256; c++) begin
            do_abort();
            send_cmd(8'(c));
            step();
            chk("R4 command decode", fast_on, (c == 8'hB5) ? 1 : 0);
        end

        // R6 temperature window sweep
        for (int t = -40; t <= 360; t++) begin
            do_abort();
            temp_code = 12'(t);
            send_cmd(8'hB5);
            step();
            chk("R6 temperature window", fast_on, (t >= 0 && t <= 320) ? 1 : 0);
        end

        // R7 hold-off flags sweep
        for (int k = 0; k < 16; k++) begin
            do_abort();
            chg_present = k[0]; conv_valid = k[1]; batt_low = k[2];
            temp_code = k[3] ? 12'sd200 : 12'sd321;
            send_cmd(8'hB5);
            step();
            chk("R7 hold-off", fast_on, (k[0] && k[1] && !k[2] && k[3]) ? 1 : 0);
            chk("R3 status", chg_stat,
                ((k[0] && k[1] && !k[2] && k[3]) || (k[0] && k[2])) ? 1 : 0);
        end

        // R8 pending starts automatically, suspend and resume
        do_abort();
        qualify_all(); conv_valid = 1'b0;
        send_cmd(8'hB5);
        repeat (5) step();
        chk("R8 pending holds", fast_on, 0);
        conv_valid = 1'b1; step();
        chk("R8 auto start", fast_on, 1);
        chk("R3 fast status", chg_stat, 1);
        temp_code = 12'sd400; step();
        chk("R8 suspend", fast_on, 0);
        temp_code = 12'sd100; step();
        chk("R8 resume", fast_on, 1);

        // R9 chemistry latch: lithium
        do_abort();
        qualify_all(); chem_sel = 1'b0;
        send_cmd(8'hB5); step();
        chem_sel = 1'b1;
        done_nimh = 1'b1; step(); done_nimh = 1'b0;
        chk("R9 lithium ignores nimh done", fast_on, 1);
        done_li = 1'b1; step(); done_li = 1'b0;
        chk("R9 lithium terminates", fast_on, 0);
        chk("R10 complete status", chg_stat, 2);

        // R10 done holds against requests, also with trickle conditions
        send_cmd(8'hB5); step();
        chk("R10 request ignored", fast_on, 0);
        chk("R10 status kept", chg_stat, 2);
        batt_low = 1'b1; step();
        chk("R10 status over trickle", chg_stat, 2);
        chk("R2 trickle in done", uv_n, 0);
        batt_low = 1'b0;
        stat_clr = 1'b1; step(); stat_clr = 1'b0;
        chk("R10 clear to idle", chg_stat, 0);

        // R9 chemistry latch: NiMH
        chem_sel = 1'b1;
        send_cmd(8'hB5); step();
        chem_sel = 1'b0;
        done_li = 1'b1; step(); done_li = 1'b0;
        chk("R9 nimh ignores lithium done", fast_on, 1);
        done_nimh = 1'b1; step(); done_nimh = 1'b0;
        chk("R9 nimh terminates", chg_stat, 2);
        stat_clr = 1'b1; step(); stat_clr = 1'b0;

        // R11 abort from fast and from pending
        send_cmd(8'hB5); step();
        chk("R11 setup fast", fast_on, 1);
        do_abort();
        chk("R11 abort from fast", fast_on, 0);
        step();
        chk("R11 stays idle", fast_on, 0);
        conv_valid = 1'b0;
        send_cmd(8'hB5);
        do_abort();
        conv_valid = 1'b1; step(); step();
        chk("R11 abort from pending", fast_on, 0);

        // R5 charger attach with and without auto_init
        chg_present = 1'b0; auto_init = 1'b0; step();
        chg_present = 1'b1; repeat (3) step();
        chk("R5 attach without auto_init", fast_on, 0);
        chg_present = 1'b0; auto_init = 1'b1; step();
        chg_present = 1'b1; step(); step();
        chk("R5 attach with auto_init", fast_on, 1);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule